// File: doc/BRIEF.md
# Byte Programming Cycle Controller

This block sequences the automatic programming of a single byte in a non-volatile array after a write-type command. When a command is accepted, it compares the new data with the byte already stored. From that comparison it picks the shortest correct sequence: an erase phase followed by a write phase, a write phase alone, or an erase phase alone. It then drives the phase indicators and the busy flag for exactly the chosen number of clocks.

The block also handles per-byte write-once lock bits. A lock bit can only be set, and a locked byte is never programmed again. The surrounding logic supplies the stored byte and lock bit for the commanded address in the same cycle as the command. At the end of the cycle the block returns a one-cycle byte update strobe and a one-cycle lock update strobe, with the address and data to store. An erased cell reads as 1 and a programmed cell reads as 0. A bit that must go from 0 to 1 therefore needs the erase phase, and a bit that must go from 1 to 0 needs the write phase.

Top module: `bytepgm_ctrl`

## Requirements
- R1: While reset is asserted and in the first sampled cycle after its release, `busy`, `erase_on`, `write_on`, `byte_wr` and `lock_wr` are all low.
- R2: A plain write (`cmd_op` = 1) that needs both a 0-to-1 and a 1-to-0 bit change gives a cycle of 203 busy clocks. `erase_on` is high for the first 100 of them and `write_on` for the next 100.
- R3: A plain write in which no bit goes from 0 to 1, but at least one goes from 1 to 0, gives a write-only cycle. It lasts 103 busy clocks, with `write_on` high for the first 100 and `erase_on` never high.
- R4: A plain write in which no bit goes from 1 to 0, but at least one goes from 0 to 1, gives an erase-only cycle. It lasts 103 busy clocks, with `erase_on` high for the first 100 and `write_on` never high.
- R5: A plain write whose data equals the stored byte starts no cycle: `busy` stays low and no strobe occurs.
- R6: A write-and-lock command (`cmd_op` = 0) always includes a write phase, because the lock bit is programmed in it. It adds an erase phase when some bit goes from 0 to 1, so it lasts 103 or 203 clocks. It ends with both `byte_wr` and `lock_wr`.
- R7: A compare-and-lock command (`cmd_op` = 2) whose data matches the stored byte runs a 103-clock write-only cycle that ends with `lock_wr` alone. On a mismatch it starts nothing.
- R8: A command is ignored, with `busy` staying low and no strobe, when the addressed byte's lock bit is set, when `access_ok` is low, or when `cmd_op` = 3.
- R9: A command presented while `busy` is high is ignored. It neither changes the running cycle's length nor the `upd_addr`/`upd_data` it reports, and it does not start a cycle afterwards.
- R10: `byte_wr` and `lock_wr` pulse for exactly one clock, in the last busy cycle, with `upd_addr` and `upd_data` holding the accepted command's address and data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | 0 write-and-lock, 1 plain write, 2 compare-and-lock, 3 reserved |
| cmd_addr | input | AW (10) | Byte address |
| cmd_data | input | DW (8) | New data, or the comparison value for compare-and-lock |
| cur_byte | input | DW (8) | Currently stored byte at `cmd_addr` |
| cur_lock | input | 1 | Currently stored lock bit at `cmd_addr` |
| access_ok | input | 1 | Modification of memory is permitted |
| busy | output | 1 | Programming cycle in progress |
| erase_on | output | 1 | Erase phase active |
| write_on | output | 1 | Write phase active |
| upd_addr | output | AW (10) | Address to update |
| upd_data | output | DW (8) | Byte value to store |
| byte_wr | output | 1 | One-cycle strobe: store `upd_data` at `upd_addr` |
| lock_wr | output | 1 | One-cycle strobe: set the lock bit at `upd_addr` |

## Verification
Several properties are checked on every clock. Every busy run lasts one of the two legal lengths, and strobes appear only in a busy cycle that is followed by idle. Blocked, equal-data and mismatching compare commands never raise `busy`, and the reported address and data stay frozen while a cycle runs. Other behaviour is shown only by the bench's scenarios: the choice between erase-only, write-only and full sequences for particular data pairs, the exact placement of the 100-clock phases, which strobes each command kind produces, and that a command injected mid-cycle leaves no trace.

// File: rtl/bytepgm_pkg.sv
package bytepgm_pkg;

  typedef enum logic [1:0] {
    OP_WR_LOCK  = 2'd0,
    OP_WR       = 2'd1,
    OP_LOCK_CMP = 2'd2,
    OP_RSVD     = 2'd3
  } op_e;

  typedef struct packed {
    logic erase;    // erase phase required
    logic write;    // write phase required
    logic wr_byte;  // byte update at end of cycle
    logic set_lock; // lock bit update at end of cycle
  } plan_t;

endpackage

// File: rtl/bytepgm_rst_sync.sv
module bytepgm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];

endmodule

// File: rtl/bytepgm_plan.sv
module bytepgm_plan
  import bytepgm_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [1:0]    op,
  input  logic [DW-1:0] new_byte,
  input  logic [DW-1:0] cur_byte,
  input  logic          cur_lock,
  input  logic          access_ok,
  output plan_t         plan,
  output logic          go
);

  logic rise_any;  // some bit must go 0 -> 1 (erase)
  logic fall_any;  // some bit must go 1 -> 0 (write)
  logic same;
  logic allowed;
  plan_t raw;

  assign rise_any = |(new_byte & ~cur_byte);
  assign fall_any = |(~new_byte & cur_byte);
  assign same     = (new_byte == cur_byte);
  assign allowed  = access_ok && !cur_lock;

  always_comb begin
    raw = '0;
    case (op_e'(op))
      OP_WR: begin
        raw.erase   = rise_any;
        raw.write   = fall_any;
        raw.wr_byte = rise_any | fall_any;
      end
      OP_WR_LOCK: begin
        raw.erase    = rise_any;
        raw.write    = 1'b1;
        raw.wr_byte  = 1'b1;
        raw.set_lock = 1'b1;
      end
      OP_LOCK_CMP: begin
        raw.write    = same;
        raw.set_lock = same;
      end
      default: raw = '0;
    endcase
  end

  assign plan = raw;
  assign go   = allowed && (raw.erase || raw.write);

endmodule

// File: rtl/bytepgm_seq.sv
module bytepgm_seq
  import bytepgm_pkg::*;
#(
  parameter int AW         = 10,
  parameter int DW         = 8,
  parameter int PHASE_CLKS = 100,
  parameter int TAIL_CLKS  = 3
) (
  input  logic          clk,
  input  logic          srst_n,
  input  logic          start,
  input  plan_t         plan,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] data_in,
  output logic          busy,
  output logic          erase_on,
  output logic          write_on,
  output logic [AW-1:0] upd_addr,
  output logic [DW-1:0] upd_data,
  output logic          byte_wr,
  output logic          lock_wr
);

  localparam int FULL_CLKS = 2 * PHASE_CLKS + TAIL_CLKS;
  localparam int HALF_CLKS = PHASE_CLKS + TAIL_CLKS;
  localparam int CW        = $clog2(FULL_CLKS + 1);
  localparam logic [CW-1:0] PH_END   = CW'(PHASE_CLKS);
  localparam logic [CW-1:0] PH2_END  = CW'(2 * PHASE_CLKS);
  localparam logic [CW-1:0] FULL_LST = CW'(FULL_CLKS - 1);
  localparam logic [CW-1:0] HALF_LST = CW'(HALF_CLKS - 1);

  logic          busy_q,  busy_d;
  logic [CW-1:0] cnt_q,   cnt_d;
  plan_t         plan_q,  plan_d;
  logic [AW-1:0] addr_q,  addr_d;
  logic [DW-1:0] data_q,  data_d;
  logic          last;

  assign last = busy_q &&
                (cnt_q == ((plan_q.erase && plan_q.write) ? FULL_LST : HALF_LST));

  // next state
  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    plan_d = plan_q;
    addr_d = addr_q;
    data_d = data_q;
    if (!busy_q) begin
      if (start) begin
        busy_d = 1'b1;
        cnt_d  = '0;
        plan_d = plan;
        addr_d = addr_in;
        data_d = data_in;
      end
    end else if (last) begin
      busy_d = 1'b0;
      cnt_d  = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  // registers
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      plan_q <= '0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      plan_q <= plan_d;
      addr_q <= addr_d;
      data_q <= data_d;
    end
  end

  assign busy     = busy_q;
  assign erase_on = busy_q && plan_q.erase && (cnt_q < PH_END);
  assign write_on = busy_q && plan_q.write &&
                    (plan_q.erase ? ((cnt_q >= PH_END) && (cnt_q < PH2_END))
                                  : (cnt_q < PH_END));
  assign upd_addr = addr_q;
  assign upd_data = data_q;
  assign byte_wr  = last && plan_q.wr_byte;
  assign lock_wr  = last && plan_q.set_lock;

endmodule

// File: rtl/bytepgm_ctrl.sv
module bytepgm_ctrl
  import bytepgm_pkg::*;
#(
  parameter int AW         = 10,
  parameter int DW         = 8,
  parameter int PHASE_CLKS = 100,
  parameter int TAIL_CLKS  = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_op,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_data,
  input  logic [DW-1:0] cur_byte,
  input  logic          cur_lock,
  input  logic          access_ok,
  output logic          busy,
  output logic          erase_on,
  output logic          write_on,
  output logic [AW-1:0] upd_addr,
  output logic [DW-1:0] upd_data,
  output logic          byte_wr,
  output logic          lock_wr
);

  logic  srst_n;
  plan_t plan;
  logic  plan_go;
  logic  start;

  bytepgm_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  bytepgm_plan #(.DW(DW)) u_plan (
    .op        (cmd_op),
    .new_byte  (cmd_data),
    .cur_byte  (cur_byte),
    .cur_lock  (cur_lock),
    .access_ok (access_ok),
    .plan      (plan),
    .go        (plan_go)
  );

  assign start = cmd_valid && !busy && plan_go;

  bytepgm_seq #(
    .AW(AW), .DW(DW), .PHASE_CLKS(PHASE_CLKS), .TAIL_CLKS(TAIL_CLKS)
  ) u_seq (
    .clk      (clk),
    .srst_n   (srst_n),
    .start    (start),
    .plan     (plan),
    .addr_in  (cmd_addr),
    .data_in  (cmd_data),
    .busy     (busy),
    .erase_on (erase_on),
    .write_on (write_on),
    .upd_addr (upd_addr),
    .upd_data (upd_data),
    .byte_wr  (byte_wr),
    .lock_wr  (lock_wr)
  );

endmodule

// File: rtl/bytepgm_chk.sv
module bytepgm_chk #(
  parameter int AW         = 10,
  parameter int DW         = 8,
  parameter int PHASE_CLKS = 100,
  parameter int TAIL_CLKS  = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic [1:0]    cmd_op,
  input logic [DW-1:0] cmd_data,
  input logic [DW-1:0] cur_byte,
  input logic          cur_lock,
  input logic          access_ok,
  input logic          busy,
  input logic [AW-1:0] upd_addr,
  input logic [DW-1:0] upd_data,
  input logic          byte_wr,
  input logic          lock_wr
);

  localparam int FULL_CLKS = 2 * PHASE_CLKS + TAIL_CLKS;
  localparam int HALF_CLKS = PHASE_CLKS + TAIL_CLKS;
  localparam int RW        = $clog2(FULL_CLKS + 2);

  logic [RW-1:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_cnt <= '0;
    else if (busy) run_cnt <= run_cnt + 1'b1;
    else           run_cnt <= '0;
  end

  // R2 R3 R4: every run has one of the two legal lengths
  assert_run_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_cnt == RW'(FULL_CLKS) || run_cnt == RW'(HALF_CLKS)));

  // R10: strobes only inside a busy cycle, which is the last one
  assert_strobe_in_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_wr || lock_wr) |-> busy);
  assert_strobe_last_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_wr || lock_wr) |=> !busy);

  // R8: locked, not permitted or reserved commands never start a cycle
  assert_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd_valid && (cur_lock || !access_ok || cmd_op == 2'd3)) |=> !busy);

  // R5: plain write of the stored value is skipped
  assert_equal_skip_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd_valid && cmd_op == 2'd1 && cmd_data == cur_byte) |=> !busy);

  // R7: compare-and-lock with mismatching data is skipped
  assert_cmp_miss_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd_valid && cmd_op == 2'd2 && cmd_data != cur_byte) |=> !busy);

  // R9: reported address and data stay frozen while a cycle runs
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(upd_addr) && $stable(upd_data)));

endmodule

bind bytepgm_ctrl bytepgm_chk #(
  .AW(AW), .DW(DW), .PHASE_CLKS(PHASE_CLKS), .TAIL_CLKS(TAIL_CLKS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_op    (cmd_op),
  .cmd_data  (cmd_data),
  .cur_byte  (cur_byte),
  .cur_lock  (cur_lock),
  .access_ok (access_ok),
  .busy      (busy),
  .upd_addr  (upd_addr),
  .upd_data  (upd_data),
  .byte_wr   (byte_wr),
  .lock_wr   (lock_wr)
);

// File: tb/test_bytepgm_ctrl.sv
module test_bytepgm_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 10;
  localparam int DW = 8;
  localparam int PH = 100;
  localparam int TL = 3;

  logic          clk;
  logic          rst_n;
  logic          cmd_valid;
  logic [1:0]    cmd_op;
  logic [AW-1:0] cmd_addr;
  logic [DW-1:0] cmd_data;
  logic [DW-1:0] cur_byte;
  logic          cur_lock;
  logic          access_ok;
  logic          busy, erase_on, write_on, byte_wr, lock_wr;
  logic [AW-1:0] upd_addr;
  logic [DW-1:0] upd_data;

  int vectors;
  int misses;
  bit done;

  typedef struct {
    int            len;
    int            ecyc;
    int            wcyc;
    bit            bw;
    bit            lw;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    string         tag;
  } exp_t;

  exp_t sb[$];

  bytepgm_ctrl #(.AW(AW), .DW(DW), .PHASE_CLKS(PH), .TAIL_CLKS(TL)) i_bytepgm_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cur_byte(cur_byte),
    .cur_lock(cur_lock), .access_ok(access_ok), .busy(busy),
    .erase_on(erase_on), .write_on(write_on), .upd_addr(upd_addr),
    .upd_data(upd_data), .byte_wr(byte_wr), .lock_wr(lock_wr)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(bit ok, string tag, string what, int act, int exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // expected outcome from the requirement text
  function automatic bit predict(input logic [1:0] op, input logic [DW-1:0] nd,
                                 input logic [DW-1:0] cd, input bit lk, input bit ok,
                                 output exp_t e);
    bit to_one, to_zero, er, wr, bw, lw;
    to_one  = ((nd & ~cd) != '0);
    to_zero = ((~nd & cd) != '0);
    er = 0; wr = 0; bw = 0; lw = 0;
    if (op == 2'd1)      begin er = to_one; wr = to_zero; bw = to_one || to_zero; end
    else if (op == 2'd0) begin er = to_one; wr = 1; bw = 1; lw = 1; end
    else if (op == 2'd2) begin wr = (nd == cd); lw = (nd == cd); end
    if (lk || !ok) begin er = 0; wr = 0; end
    e.ecyc = er ? PH : 0;
    e.wcyc = wr ? PH : 0;
    e.len  = (er && wr) ? 2*PH + TL : ((er || wr) ? PH + TL : 0);
    e.bw   = bw;
    e.lw   = lw;
    return er || wr;
  endfunction

  // driver: presents one command, pushes the expectation, waits for completion
  task automatic issue(input logic [1:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input logic [DW-1:0] c, input bit lk, input bit ok,
                       input string tag, input bit inject);
    exp_t e;
    bit run;
    run = predict(op, d, c, lk, ok, e);
    e.addr = a; e.data = d; e.tag = tag;
    if (run) sb.push_back(e);
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_addr = a; cmd_data = d;
    cur_byte = c; cur_lock = lk; access_ok = ok;
    @(negedge clk);
    cmd_valid = 0;
    if (!run) begin
      repeat (3) @(negedge clk);
      check(busy == 0, tag, "busy after ignored command", busy, 0);
    end else begin
      if (inject) begin
        repeat (40) @(negedge clk);
        cmd_valid = 1; cmd_op = 2'd1; cmd_addr = 10'h3FF; cmd_data = 8'h00;
        cur_byte = 8'hFF; cur_lock = 0; access_ok = 1;
        @(negedge clk);
        cmd_valid = 0;
      end
      while (busy) @(negedge clk);
      repeat (3) @(negedge clk);
      check(busy == 0, tag, "idle after cycle", busy, 0);
    end
  endtask

  // monitor: measures each busy run and compares it with the queued item
  int  rlen, recyc, rwcyc, rbw, rlw, spos;
  logic [AW-1:0] saddr;
  logic [DW-1:0] sdata;
  bit  in_run;

  initial begin
    in_run = 0;
    forever begin
      @(negedge clk);
      if (rst_n && !done) begin
        if (busy) begin
          if (!in_run) begin
            in_run = 1; rlen = 0; recyc = 0; rwcyc = 0; rbw = 0; rlw = 0; spos = 0;
          end
          rlen++;
          if (erase_on) begin
            recyc++;
            if (rwcyc != 0) check(0, "R2", "erase after write", rlen, 0);
          end
          if (write_on) rwcyc++;
          if (byte_wr || lock_wr) begin
            spos = rlen; saddr = upd_addr; sdata = upd_data;
            if (byte_wr) rbw++;
            if (lock_wr) rlw++;
          end
        end else begin
          if (byte_wr || lock_wr) check(0, "R10", "strobe while idle", 1, 0);
          if (in_run) begin
            exp_t e;
            in_run = 0;
            if (sb.size() == 0) begin
              check(0, "R9", "unexpected cycle", rlen, 0);
            end else begin
              e = sb.pop_front();
              check(rlen == e.len, e.tag, "busy length", rlen, e.len);
              check(recyc == e.ecyc, e.tag, "erase clocks", recyc, e.ecyc);
              check(rwcyc == e.wcyc, e.tag, "write clocks", rwcyc, e.wcyc);
              check(rbw == int'(e.bw), e.tag, "byte_wr pulses", rbw, int'(e.bw));
              check(rlw == int'(e.lw), e.tag, "lock_wr pulses", rlw, int'(e.lw));
              if (e.bw || e.lw) begin
                check(spos == e.len, "R10", "strobe position", spos, e.len);
                check(saddr == e.addr, e.tag, "upd_addr", int'(saddr), int'(e.addr));
                check(sdata == e.data, e.tag, "upd_data", int'(sdata), int'(e.data));
              end
            end
          end
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    vectors++; misses++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    vectors = 0; misses = 0; done = 0;
    rst_n = 0; cmd_valid = 0; cmd_op = 0; cmd_addr = 0; cmd_data = 0;
    cur_byte = 0; cur_lock = 0; access_ok = 1;
    repeat (4) @(negedge clk);
    // R1: reset state
    check({busy, erase_on, write_on, byte_wr, lock_wr} == 5'b0, "R1", "outputs in reset",
          int'({busy, erase_on, write_on, byte_wr, lock_wr}), 0);
    rst_n = 1;
    @(negedge clk);
    check({busy, erase_on, write_on, byte_wr, lock_wr} == 5'b0, "R1", "outputs after release",
          int'({busy, erase_on, write_on, byte_wr, lock_wr}), 0);
    repeat (3) @(negedge clk);

    issue(2'd1, 10'h155, 8'h0F, 8'hF0, 0, 1, "R2", 0);  // both directions
    issue(2'd1, 10'h001, 8'hA5, 8'hFF, 0, 1, "R3", 0);  // 1->0 only
    issue(2'd1, 10'h3FC, 8'h3C, 8'h00, 0, 1, "R4", 0);  // 0->1 only
    issue(2'd1, 10'h0AA, 8'h5A, 8'h5A, 0, 1, "R5", 0);  // equal data
    issue(2'd0, 10'h0AA, 8'h5A, 8'h5A, 0, 1, "R6", 0);  // lock, write-only
    issue(2'd0, 10'h200, 8'hFF, 8'h00, 0, 1, "R6", 0);  // lock, erase+write
    issue(2'd2, 10'h123, 8'h77, 8'h77, 0, 1, "R7", 0);  // compare hit
    issue(2'd2, 10'h124, 8'h76, 8'h77, 0, 1, "R7", 0);  // compare miss
    issue(2'd1, 10'h010, 8'h0F, 8'hF0, 1, 1, "R8", 0);  // locked byte
    issue(2'd0, 10'h011, 8'h0F, 8'hF0, 0, 0, "R8", 0);  // no access
    issue(2'd3, 10'h012, 8'h0F, 8'hF0, 0, 1, "R8", 0);  // reserved op
    issue(2'd1, 10'h077, 8'h81, 8'h7E, 0, 1, "R9", 1);  // injection mid-cycle
    issue(2'd1, 10'h000, 8'h00, 8'h01, 0, 1, "R3", 0);  // single bit write

    repeat (5) @(negedge clk);
    check(sb.size() == 0, "R9", "pending expectations", sb.size(), 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule